// File: doc/BRIEF.md
# DS3 Framing and Parity Error Injector

This block sits on the serial transmit path of a DS3 framer, after the overhead bits have been generated. It corrupts chosen overhead bits on purpose so that a far-end receiver's alarm and error counting can be tested. Each clock carries one line bit. The upstream framer supplies that bit together with a tag that says what the bit is (data, F-bit, M-bit or P-bit), the bit's index within its group, and a start-of-frame marker. The block returns the same stream one clock later, with the selected bits inverted.

Framing errors come in four kinds. A single F-bit error inverts one F-bit. A single M-bit error inverts one M-bit. A subframe error inverts the four F-bits of one subframe. A multiframe-loss error inverts one M-bit in each of two back-to-back frames. Parity errors invert both P-bits of one frame, either once for each request or in every frame. A request to inject comes either from a register strobe or from an external pin, and one select input chooses between the two sources. The pin is synchronized and edge-detected, so one pulse on it gives one request.

A `busy` output shows that an injection is armed, running or pending. A one-cycle `done` pulse marks the last corrupted bit of each requested injection.

Top module: `ds3_err_inject`

## Requirements
- R1: While reset is asserted, `dout`, `busy` and `done` are all 0.
- R2: When no injection is active, `dout` equals the `din` value of the previous clock.
- R3: With `fe_mode`=0 (F-bit), one framing request inverts exactly one bit: the first bit tagged F (`bit_kind`=1) after the request.
- R4: With `fe_mode`=1 (M-bit), one framing request inverts exactly one bit: the first bit tagged M (`bit_kind`=2) after the request.
- R5: With `fe_mode`=2 (subframe), one request inverts the four F-bits of the next subframe, which begins with `bit_idx`=0 and ends with `bit_idx`=3.
- R6: With `fe_mode`=3 (multiframe), one request inverts the first M-bit after the request and then the first M-bit after the next `sof`, two bits in total.
- R7: With `pe_cont`=0, one parity request inverts the P-bit with `bit_idx`=0 that comes next (`bit_kind`=3), and then the following P-bit: two bits in one frame.
- R8: With `pe_cont`=1 and `pe_en`=1, every P-bit is inverted, parity requests are ignored, and `busy` stays low because of parity.
- R9: A request for a type whose enable is low is ignored. Clearing an enable aborts that type's armed, running and pending work at the next clock.
- R10: With `src_pin`=1, each rising edge of `ext_req` gives exactly one request to both types, and the strobes are ignored. With `src_pin`=0, only `sw_fe_req` and `sw_pe_req` count and `ext_req` is ignored.
- R11: A request that arrives while an injection of the same type is armed or running is held, one deep, and starts once that injection completes.
- R12: The framing mode is captured when a request is armed. Changing `fe_mode` afterwards does not change the injection in progress.
- R13: `busy` is high from the clock after a request until the injection completes. `done` pulses for one cycle together with the final inverted bit on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial line bit in |
| bit_kind | input | 2 | Tag of `din`: 0 data, 1 F-bit, 2 M-bit, 3 P-bit |
| bit_idx | input | 2 | Index of `din` within its group (F 0..3, M 0..2, P 0..1) |
| sof | input | 1 | High on the first bit of each frame |
| fe_en | input | 1 | Framing error enable |
| fe_mode | input | 2 | Framing kind: 0 F-bit, 1 M-bit, 2 subframe, 3 multiframe |
| pe_en | input | 1 | Parity error enable |
| pe_cont | input | 1 | 1 gives continuous parity errors, 0 gives one frame per request |
| src_pin | input | 1 | Request source: 1 external pin, 0 register strobes |
| sw_fe_req | input | 1 | Framing request strobe, one cycle |
| sw_pe_req | input | 1 | Parity request strobe, one cycle |
| ext_req | input | 1 | Asynchronous request pin, serves both types |
| dout | output | 1 | Serial line bit out, one clock after `din` |
| busy | output | 1 | An injection is armed, running or pending |
| done | output | 1 | One-cycle pulse with the last inverted bit of an injection |

## Verification
The assertions take for granted that the tags describe a well-formed frame. F-bits come in groups with indices 0 to 3 in order, P-bits with index 0 come before index 1 within a frame, and `sof` never falls on an M-bit. The stimulus repeats one fixed 40-bit frame layout that keeps to these rules, and it uses random payload bits. Requests are spaced so that none lands in the one cycle when a pending request is being promoted. Pin pulses are held for several clocks so that the synchronizer sees them.

// File: rtl/ds3_inj_pkg.sv
package ds3_inj_pkg;

  typedef enum logic [1:0] {
    BK_DATA = 2'd0,
    BK_FBIT = 2'd1,
    BK_MBIT = 2'd2,
    BK_PBIT = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    FM_FBIT = 2'd0,
    FM_MBIT = 2'd1,
    FM_SUBF = 2'd2,
    FM_MULT = 2'd3
  } fmode_e;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_ARM   = 3'd1,
    FS_SUBF  = 3'd2,
    FS_WAITF = 3'd3,
    FS_ARM2  = 3'd4
  } fstate_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ARM  = 2'd1,
    PS_SEC  = 2'd2
  } pstate_e;

endpackage

// File: rtl/ds3_inj_req.sv
module ds3_inj_req #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic src_pin,
  input  logic sw_fe_req,
  input  logic sw_pe_req,
  output logic fe_req,
  output logic pe_req
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         last_q, last_d;
  logic         pin_edge;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], ext_req};
    last_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign pin_edge = sync_q[TOP] & ~last_q;
  assign fe_req   = src_pin ? pin_edge : sw_fe_req;
  assign pe_req   = src_pin ? pin_edge : sw_pe_req;

  // R10: a held pin level yields a single request
  p_pin_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> !pin_edge);

endmodule

// File: rtl/ds3_inj_frame.sv
module ds3_inj_frame
  import ds3_inj_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int F_PER_SUB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req,
  input  fmode_e           mode_in,
  input  kind_e            kind,
  input  logic [IDX_W-1:0] idx,
  input  logic             sof,
  output logic             flip,
  output logic             done,
  output logic             busy
);
  localparam logic [IDX_W-1:0] F_LAST = IDX_W'(F_PER_SUB - 1);

  fstate_e st_q, st_d;
  fmode_e  mode_q, mode_d;
  logic    pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    pend_d = pend_q;
    flip   = 1'b0;
    done   = 1'b0;
    if (!en) begin
      st_d   = FS_IDLE;
      pend_d = 1'b0;
    end else begin
      if (st_q != FS_IDLE && req) pend_d = 1'b1;
      case (st_q)
        FS_IDLE: begin
          if (req || pend_q) begin
            st_d   = FS_ARM;
            mode_d = mode_in;
            pend_d = 1'b0;
          end
        end
        FS_ARM: begin
          case (mode_q)
            FM_FBIT: if (kind == BK_FBIT) begin
              flip = 1'b1; done = 1'b1; st_d = FS_IDLE;
            end
            FM_MBIT: if (kind == BK_MBIT) begin
              flip = 1'b1; done = 1'b1; st_d = FS_IDLE;
            end
            FM_SUBF: if (kind == BK_FBIT && idx == '0) begin
              flip = 1'b1; st_d = FS_SUBF;
            end
            default: if (kind == BK_MBIT) begin
              flip = 1'b1; st_d = FS_WAITF;
            end
          endcase
        end
        FS_SUBF: begin
          if (kind == BK_FBIT) begin
            flip = 1'b1;
            if (idx == F_LAST) begin
              done = 1'b1; st_d = FS_IDLE;
            end
          end
        end
        FS_WAITF: if (sof) st_d = FS_ARM2;
        FS_ARM2: if (kind == BK_MBIT) begin
          flip = 1'b1; done = 1'b1; st_d = FS_IDLE;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      mode_q <= FM_FBIT;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign busy = (st_q != FS_IDLE) | pend_q;

  // R9: dropping the enable clears all framing work
  p_abort_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == FS_IDLE && !pend_q));

  // R6: the second multiframe hit is only reached through the frame wait
  p_mult_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_ARM2) |-> ($past(st_q) == FS_WAITF || $past(st_q) == FS_ARM2));

  // R5: a subframe burst starts only on the first F-bit of a subframe
  p_subf_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_SUBF && $past(st_q) == FS_ARM) |->
      ($past(kind) == BK_FBIT && $past(idx) == '0));

endmodule

// File: rtl/ds3_inj_parity.sv
module ds3_inj_parity
  import ds3_inj_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cont,
  input  logic             req,
  input  kind_e            kind,
  input  logic [IDX_W-1:0] idx,
  output logic             flip,
  output logic             done,
  output logic             busy
);
  pstate_e st_q, st_d;
  logic    pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    flip   = 1'b0;
    done   = 1'b0;
    if (!en) begin
      st_d   = PS_IDLE;
      pend_d = 1'b0;
    end else if (cont) begin
      st_d   = PS_IDLE;
      pend_d = 1'b0;
      flip   = (kind == BK_PBIT);
    end else begin
      if (st_q != PS_IDLE && req) pend_d = 1'b1;
      case (st_q)
        PS_IDLE: if (req || pend_q) begin
          st_d = PS_ARM; pend_d = 1'b0;
        end
        PS_ARM: if (kind == BK_PBIT && idx == '0) begin
          flip = 1'b1; st_d = PS_SEC;
        end
        PS_SEC: if (kind == BK_PBIT) begin
          flip = 1'b1; done = 1'b1; st_d = PS_IDLE;
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign busy = (st_q != PS_IDLE) | pend_q;

  // R8: continuous mode never leaves a single-shot sequence armed
  p_cont_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cont) |=> (st_q == PS_IDLE && !pend_q));

  // R7: the second parity hit follows the first
  p_second_after_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SEC && $past(st_q) == PS_ARM) |-> ($past(kind) == BK_PBIT));

endmodule

// File: rtl/ds3_err_inject.sv
module ds3_err_inject
  import ds3_inj_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int F_PER_SUB   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [1:0]       bit_kind,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             sof,
  input  logic             fe_en,
  input  logic [1:0]       fe_mode,
  input  logic             pe_en,
  input  logic             pe_cont,
  input  logic             src_pin,
  input  logic             sw_fe_req,
  input  logic             sw_pe_req,
  input  logic             ext_req,
  output logic             dout,
  output logic             busy,
  output logic             done
);
  localparam int RTOP = RST_STAGES - 1;

  logic [RTOP:0] rst_pipe_q;
  logic          rst_ns;
  logic          fe_req, pe_req;
  logic          f_flip, f_done, f_busy;
  logic          p_flip, p_done, p_busy;
  logic          dout_q, dout_d, done_q, done_d;
  kind_e         kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RTOP-1:0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[RTOP];

  assign kind = kind_e'(bit_kind);

  ds3_inj_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst_n(rst_ns), .ext_req(ext_req), .src_pin(src_pin),
    .sw_fe_req(sw_fe_req), .sw_pe_req(sw_pe_req),
    .fe_req(fe_req), .pe_req(pe_req)
  );

  ds3_inj_frame #(.IDX_W(IDX_W), .F_PER_SUB(F_PER_SUB)) u_frame (
    .clk(clk), .rst_n(rst_ns), .en(fe_en), .req(fe_req),
    .mode_in(fmode_e'(fe_mode)), .kind(kind), .idx(bit_idx), .sof(sof),
    .flip(f_flip), .done(f_done), .busy(f_busy)
  );

  ds3_inj_parity #(.IDX_W(IDX_W)) u_par (
    .clk(clk), .rst_n(rst_ns), .en(pe_en), .cont(pe_cont), .req(pe_req),
    .kind(kind), .idx(bit_idx),
    .flip(p_flip), .done(p_done), .busy(p_busy)
  );

  always_comb begin
    dout_d = din ^ (f_flip | p_flip);
    done_d = f_done | p_done;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dout_q <= dout_d;
      done_q <= done_d;
    end
  end

  assign dout = dout_q;
  assign done = done_q;
  assign busy = f_busy | p_busy;

  // R2: with both types disabled the stream passes unchanged
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!fe_en && !pe_en) |=> (dout == $past(din)));

  // R13: completion only comes out of an active injection
  p_done_needs_busy_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> $past(busy));

  // R1: outputs idle while the internal reset holds
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ns |-> (!dout && !done && !busy));

endmodule

// File: tb/ds3_err_inject_tb.sv
module ds3_err_inject_tb;
  localparam int FLEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, sof = 1'b0;
  logic [1:0] bit_kind = 2'd0, bit_idx = 2'd0;
  logic fe_en = 1'b0, pe_en = 1'b0, pe_cont = 1'b0, src_pin = 1'b0;
  logic [1:0] fe_mode = 2'd0;
  logic sw_fe_req = 1'b0, sw_pe_req = 1'b0, ext_req = 1'b0;
  logic dout, busy, done;

  int checks = 0, fails = 0;
  int pos = 0;
  int inv_cnt = 0, done_cnt = 0;
  bit chk_on = 1'b0, finished = 1'b0;
  string cur_tag = "R2";

  // reference model state
  int  m_fs = 0, m_fmode = 0, m_ps = 0;
  bit  m_fpend = 0, m_ppend = 0;
  bit  exp_dout = 0, exp_done = 0, exp_busy = 0, din_last = 0;
  bit  pin_hist[$];

  ds3_err_inject u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .bit_kind(bit_kind), .bit_idx(bit_idx),
    .sof(sof), .fe_en(fe_en), .fe_mode(fe_mode), .pe_en(pe_en), .pe_cont(pe_cont),
    .src_pin(src_pin), .sw_fe_req(sw_fe_req), .sw_pe_req(sw_pe_req),
    .ext_req(ext_req), .dout(dout), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  // frame layout: F groups at 2,7,12,17 and 22,27,32,37; M at 4,14,24; P at 9,19
  function automatic void tag_of(input int p, output logic [1:0] k, output logic [1:0] i);
    k = 2'd0; i = 2'd0;
    if (p % 5 == 2) begin k = 2'd1; i = 2'((p / 5) % 4); end
    else if (p == 4 || p == 14 || p == 24) begin k = 2'd2; i = 2'(p / 10); end
    else if (p == 9 || p == 19) begin k = 2'd3; i = 2'(p / 10); end
  endfunction

  always @(negedge clk) begin
    logic [1:0] k, i;
    tag_of(pos, k, i);
    bit_kind <= k;
    bit_idx  <= i;
    sof      <= (pos == 0);
    din      <= 1'($urandom_range(0, 1));
    pos      <= (pos + 1) % FLEN;
  end

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    bit rf, rp, pulse, ff, fd, pf, pd;
    int os;
    pin_hist.push_front(ext_req);
    if (pin_hist.size() > 4) void'(pin_hist.pop_back());
    pulse = (pin_hist.size() == 4) && pin_hist[2] && !pin_hist[3];
    rf = src_pin ? pulse : sw_fe_req;
    rp = src_pin ? pulse : sw_pe_req;
    ff = 0; fd = 0; pf = 0; pd = 0;
    if (!fe_en) begin m_fs = 0; m_fpend = 0; end
    else begin
      os = m_fs;
      if (os != 0 && rf) m_fpend = 1;
      if (os == 0) begin
        if (rf || m_fpend) begin m_fs = 1; m_fmode = fe_mode; m_fpend = 0; end
      end else if (os == 1) begin
        if (m_fmode == 0 && bit_kind == 1) begin ff = 1; fd = 1; m_fs = 0; end
        if (m_fmode == 1 && bit_kind == 2) begin ff = 1; fd = 1; m_fs = 0; end
        if (m_fmode == 2 && bit_kind == 1 && bit_idx == 0) begin ff = 1; m_fs = 2; end
        if (m_fmode == 3 && bit_kind == 2) begin ff = 1; m_fs = 3; end
      end else if (os == 2) begin
        if (bit_kind == 1) begin ff = 1; if (bit_idx == 3) begin fd = 1; m_fs = 0; end end
      end else if (os == 3) begin
        if (sof) m_fs = 4;
      end else begin
        if (bit_kind == 2) begin ff = 1; fd = 1; m_fs = 0; end
      end
    end
    if (!pe_en) begin m_ps = 0; m_ppend = 0; end
    else if (pe_cont) begin m_ps = 0; m_ppend = 0; pf = (bit_kind == 3); end
    else begin
      os = m_ps;
      if (os != 0 && rp) m_ppend = 1;
      if (os == 0) begin
        if (rp || m_ppend) begin m_ps = 1; m_ppend = 0; end
      end else if (os == 1) begin
        if (bit_kind == 3 && bit_idx == 0) begin pf = 1; m_ps = 2; end
      end else if (bit_kind == 3) begin pf = 1; pd = 1; m_ps = 0; end
    end
    din_last = din;
    exp_dout = din ^ (ff | pf);
    exp_done = fd | pd;
    exp_busy = (m_fs != 0) || m_fpend || (m_ps != 0) || m_ppend;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check({cur_tag, " dout"}, dout, exp_dout);
      check({cur_tag, " done"}, done, exp_done);
      check({cur_tag, " busy"}, busy, exp_busy);
      if (dout != din_last) inv_cnt++;
      if (done) done_cnt++;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_pulse(input bit fe);
    @(negedge clk);
    if (fe) sw_fe_req = 1'b1; else sw_pe_req = 1'b1;
    @(negedge clk);
    sw_fe_req = 1'b0; sw_pe_req = 1'b0;
  endtask

  task automatic expect_burst(input string tag, input bit fe, input int n,
                              input int want_inv, input int want_done);
    int i0, d0;
    cur_tag = tag;
    i0 = inv_cnt; d0 = done_cnt;
    sw_pulse(fe);
    run(n);
    check({tag, " inverted bits"}, inv_cnt - i0, want_inv);
    check({tag, " done pulses"}, done_cnt - d0, want_done);
  endtask

  initial begin
    int i0, d0;
    run(3);
    // R1: outputs quiet during reset
    check("R1 dout", dout, 0); check("R1 busy", busy, 0); check("R1 done", done, 0);
    rst_n = 1'b1;
    run(6);
    chk_on = 1'b1;

    // R2 and R9: nothing enabled, requests are ignored
    cur_tag = "R9";
    i0 = inv_cnt;
    sw_pulse(1); sw_pulse(0);
    run(80);
    check("R2 passthrough", inv_cnt - i0, 0);

    fe_en = 1'b1;
    fe_mode = 2'd0; expect_burst("R3", 1, 100, 1, 1);
    fe_mode = 2'd1; expect_burst("R4", 1, 100, 1, 1);
    fe_mode = 2'd2; expect_burst("R5", 1, 100, 4, 1);
    fe_mode = 2'd3; expect_burst("R6", 1, 130, 2, 1);
    fe_en = 1'b0;

    pe_en = 1'b1;
    expect_burst("R7", 0, 100, 2, 1);
    // R8: continuous parity over exactly two frames, request ignored
    pe_cont = 1'b1;
    run(2);
    expect_burst("R8", 0, 78, 4, 0);
    pe_cont = 1'b0; pe_en = 1'b0;
    run(4);

    // R10: pin source, a long pulse gives one request
    cur_tag = "R10";
    fe_en = 1'b1; fe_mode = 2'd0; src_pin = 1'b1;
    i0 = inv_cnt;
    run(1); ext_req = 1'b1; run(6); ext_req = 1'b0;
    run(100);
    check("R10 pin single request", inv_cnt - i0, 1);
    i0 = inv_cnt;
    sw_pulse(1); run(100);
    check("R10 strobe ignored with pin source", inv_cnt - i0, 0);
    src_pin = 1'b0;
    i0 = inv_cnt;
    ext_req = 1'b1; run(6); ext_req = 1'b0; run(100);
    check("R10 pin ignored with strobe source", inv_cnt - i0, 0);

    // R11: second request during a subframe burst is held
    cur_tag = "R11";
    fe_mode = 2'd2;
    i0 = inv_cnt; d0 = done_cnt;
    sw_pulse(1); run(3); sw_pulse(1);
    run(200);
    check("R11 two bursts", inv_cnt - i0, 8);
    check("R11 two completions", done_cnt - d0, 2);

    // R12: mode change after arming has no effect
    cur_tag = "R12";
    fe_mode = 2'd3;
    i0 = inv_cnt;
    sw_pulse(1); fe_mode = 2'd0;
    run(130);
    check("R12 latched multiframe", inv_cnt - i0, 2);

    // R9: abort by clearing the enable before the first F-bit of a subframe
    cur_tag = "R9";
    fe_mode = 2'd2;
    while (pos != 5) @(negedge clk);
    sw_pulse(1); run(1);
    check("R13 busy while armed", busy, 1);
    fe_en = 1'b0;
    run(2);
    i0 = inv_cnt;
    check("R9 busy cleared", busy, 0);
    run(80);
    check("R9 aborted burst", inv_cnt - i0, 0);

    chk_on = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule